// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block is a small, fully associative translation buffer. Each slot covers a pair of adjacent virtual pages and holds two physical frame records, one for the even page and one for the odd page. A later stage picks one of the two using an address bit. Each slot also stores a per-bit page mask, so one slot can cover a larger region. A global flag in the slot lets it match any address-space identifier.

There are several independent access paths, all served in the same cycle. The translate path compares a page number and identifier against every slot. One cycle later it returns a hit flag, the index of the winning slot and both frame words. The search path runs the same comparison and returns only the index, or an all-ones code when nothing matches. An indexed load port writes a whole slot. An indexed read port returns a slot as four packed words. A flush input empties the table in one cycle. A round-robin victim pointer names the next slot to refill and steps forward only on request.

Top module: `tlbp_pair_tlb`

## Requirements
- R1: A slot matches when the incoming page number equals the stored one on every bit where the slot's mask bit is 0. Bits whose mask bit is 1 are ignored.
- R2: The identifier must equal the stored one unless the slot's global flag is 1. When the flag is 1, any identifier matches.
- R3: A slot whose even and odd valid bits are both 0 never matches, whatever else it holds.
- R4: When several slots match, the lowest index wins. `lk_hit`, `lk_idx`, `lk_lo0` and `lk_lo1` reflect the inputs of the previous cycle. On a miss, `lk_idx`, `lk_lo0` and `lk_lo1` are 0.
- R5: The search path reports the lowest matching index in `pr_result` with `pr_miss` = 0. When nothing matches, `pr_result` is all ones (-1) and `pr_miss` = 1. Both reflect the previous cycle's inputs.
- R6: A load with `wr_en` = 1 and `wr_idx` < ENTRIES replaces that slot from the next cycle on. A load with `wr_idx` >= ENTRIES changes no slot.
- R7: Read-back words use these layouts. A frame word is frame<<6 | attr<<3 | dirty<<2 | valid<<1 | global. The tag word is page<<11 | identifier. The mask word is mask<<11. The read is registered one cycle, and unused bits are 0.
- R8: `flush` zeroes every slot and sets the victim pointer to 0. A load in the same cycle is dropped.
- R9: `rp_idx` holds its value unless `rp_adv` = 1. On advance it goes to the next index, and from ENTRIES-1 it wraps to 0.
- R10: After reset the table is empty, `lk_hit` = 0, `pr_miss` = 1, `pr_result` is all ones, `rp_idx` = 0 and the read words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the table and clear the victim pointer |
| lk_vpn | input | 19 | Translate path page number |
| lk_asid | input | 8 | Translate path identifier |
| lk_hit | output | 1 | Registered hit flag |
| lk_idx | output | IDX_W (3) | Registered winning index |
| lk_lo0 | output | 32 | Even frame word of winner |
| lk_lo1 | output | 32 | Odd frame word of winner |
| pr_vpn | input | 19 | Search path page number |
| pr_asid | input | 8 | Search path identifier |
| pr_miss | output | 1 | Search found nothing |
| pr_result | output | IDX_W+1 (4) | Index found, all ones when none |
| wr_en | input | 1 | Load strobe |
| wr_idx | input | IDX_W+1 (4) | Slot to load, out-of-range ignored |
| wr_vpn | input | 19 | Page number to store |
| wr_asid | input | 8 | Identifier to store |
| wr_mask | input | 19 | Page mask, 1 = ignore bit |
| wr_global | input | 1 | Global flag |
| wr_pfn0 | input | 20 | Even frame number |
| wr_attr0 | input | 3 | Even cache attribute |
| wr_dirty0 | input | 1 | Even dirty bit |
| wr_valid0 | input | 1 | Even valid bit |
| wr_pfn1 | input | 20 | Odd frame number |
| wr_attr1 | input | 3 | Odd cache attribute |
| wr_dirty1 | input | 1 | Odd dirty bit |
| wr_valid1 | input | 1 | Odd valid bit |
| rd_idx | input | IDX_W (3) | Slot to read back |
| rd_lo0 | output | 32 | Even frame word |
| rd_lo1 | output | 32 | Odd frame word |
| rd_hi | output | 32 | Tag word |
| rd_mask | output | 32 | Mask word |
| rp_adv | input | 1 | Step the victim pointer |
| rp_idx | output | IDX_W (3) | Current victim index |

## Verification
The bench builds the block with the default of eight slots. With eight slots the victim pointer wraps after a handful of steps. A 4-bit load index easily reaches the ignored range 8 to 15. Random page numbers are drawn from a 16-value space, with masks of 0, 1 or 3 and identifiers from 0 to 3. This makes overlapping matches, global overrides and lowest-index priority occur often, not rarely.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;

    localparam int VPN_W       = 19;
    localparam int ASID_W      = 8;
    localparam int PFN_W       = 20;
    localparam int ATTR_W      = 3;
    localparam int WORD_W      = 32;
    localparam int TAG_SHIFT   = 11;
    localparam int FRAME_SHIFT = 6;
    localparam int ATTR_SHIFT  = 3;

    typedef struct packed {
        logic [PFN_W-1:0]  pfn;
        logic [ATTR_W-1:0] attr;
        logic              dirty;
        logic              valid;
    } frame_t;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  mask;
        logic              glob;
        frame_t            even;
        frame_t            odd;
    } slot_t;

    function automatic logic [WORD_W-1:0] pack_frame(input frame_t f, input logic g);
        logic [WORD_W-1:0] w;
        w = '0;
        w[FRAME_SHIFT +: PFN_W]  = f.pfn;
        w[ATTR_SHIFT +: ATTR_W]  = f.attr;
        w[2]                     = f.dirty;
        w[1]                     = f.valid;
        w[0]                     = g;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] pack_tag(input logic [VPN_W-1:0] v,
                                                   input logic [ASID_W-1:0] a);
        logic [WORD_W-1:0] w;
        w = '0;
        w[TAG_SHIFT +: VPN_W] = v;
        w[0 +: ASID_W]        = a;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] pack_mask(input logic [VPN_W-1:0] m);
        logic [WORD_W-1:0] w;
        w = '0;
        w[TAG_SHIFT +: VPN_W] = m;
        return w;
    endfunction

endpackage

// File: rtl/tlbp_match_bank.sv
module tlbp_match_bank
    import tlbp_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  slot_t [ENTRIES-1:0] slots,
    input  logic [VPN_W-1:0]    key_vpn,
    input  logic [ASID_W-1:0]   key_asid,
    output logic [ENTRIES-1:0]  hits
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic page_eq;
        logic id_eq;
        logic present;
        assign page_eq = (((key_vpn ^ slots[g].vpn) & ~slots[g].mask) == '0);
        assign id_eq   = slots[g].glob || (key_asid == slots[g].asid);
        assign present = slots[g].even.valid || slots[g].odd.valid;
        assign hits[g] = page_eq && id_eq && present;
    end

endmodule

// File: rtl/tlbp_first_hit.sv
module tlbp_first_hit #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic [ENTRIES-1:0] hits,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hits[i]) begin
                found = 1'b1;
                idx   = i[IDX_W-1:0];
            end
        end
    end

endmodule

// File: rtl/tlbp_rr_ptr.sv
module tlbp_rr_ptr #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (clear) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

endmodule

// File: rtl/tlbp_pair_tlb.sv
module tlbp_pair_tlb
    import tlbp_pkg::*;
#(
    parameter  int ENTRIES = 8,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int WIDX_W  = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [WORD_W-1:0] lk_lo0,
    output logic [WORD_W-1:0] lk_lo1,
    input  logic [VPN_W-1:0]  pr_vpn,
    input  logic [ASID_W-1:0] pr_asid,
    output logic              pr_miss,
    output logic [WIDX_W-1:0] pr_result,
    input  logic              wr_en,
    input  logic [WIDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [VPN_W-1:0]  wr_mask,
    input  logic              wr_global,
    input  logic [PFN_W-1:0]  wr_pfn0,
    input  logic [ATTR_W-1:0] wr_attr0,
    input  logic              wr_dirty0,
    input  logic              wr_valid0,
    input  logic [PFN_W-1:0]  wr_pfn1,
    input  logic [ATTR_W-1:0] wr_attr1,
    input  logic              wr_dirty1,
    input  logic              wr_valid1,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_lo0,
    output logic [WORD_W-1:0] rd_lo1,
    output logic [WORD_W-1:0] rd_hi,
    output logic [WORD_W-1:0] rd_mask,
    input  logic              rp_adv,
    output logic [IDX_W-1:0]  rp_idx
);

    localparam logic [WIDX_W-1:0] SLOT_CNT = WIDX_W'(ENTRIES);

    slot_t [ENTRIES-1:0] slot_q;
    slot_t               wr_slot;
    logic                wr_ok;

    assign wr_slot.vpn        = wr_vpn;
    assign wr_slot.asid       = wr_asid;
    assign wr_slot.mask       = wr_mask;
    assign wr_slot.glob       = wr_global;
    assign wr_slot.even.pfn   = wr_pfn0;
    assign wr_slot.even.attr  = wr_attr0;
    assign wr_slot.even.dirty = wr_dirty0;
    assign wr_slot.even.valid = wr_valid0;
    assign wr_slot.odd.pfn    = wr_pfn1;
    assign wr_slot.odd.attr   = wr_attr1;
    assign wr_slot.odd.dirty  = wr_dirty1;
    assign wr_slot.odd.valid  = wr_valid1;

    assign wr_ok = wr_en && (wr_idx < SLOT_CNT);

    // Slot storage: flush dominates, out-of-range loads drop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (flush) begin
            slot_q <= '0;
        end else if (wr_ok) begin
            slot_q[wr_idx[IDX_W-1:0]] <= wr_slot;
        end
    end

    // Translate path
    logic [ENTRIES-1:0] lk_hits;
    logic               lk_found;
    logic [IDX_W-1:0]   lk_win;

    tlbp_match_bank #(.ENTRIES(ENTRIES)) u_lk_bank (
        .slots    (slot_q),
        .key_vpn  (lk_vpn),
        .key_asid (lk_asid),
        .hits     (lk_hits)
    );

    tlbp_first_hit #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lk_pick (
        .hits  (lk_hits),
        .found (lk_found),
        .idx   (lk_win)
    );

    slot_t lk_sel;
    assign lk_sel = slot_q[lk_win];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_hit <= 1'b0;
            lk_idx <= '0;
            lk_lo0 <= '0;
            lk_lo1 <= '0;
        end else begin
            lk_hit <= lk_found;
            lk_idx <= lk_found ? lk_win : '0;
            lk_lo0 <= lk_found ? pack_frame(lk_sel.even, lk_sel.glob) : '0;
            lk_lo1 <= lk_found ? pack_frame(lk_sel.odd, lk_sel.glob) : '0;
        end
    end

    // Search path
    logic [ENTRIES-1:0] pr_hits;
    logic               pr_found;
    logic [IDX_W-1:0]   pr_win;

    tlbp_match_bank #(.ENTRIES(ENTRIES)) u_pr_bank (
        .slots    (slot_q),
        .key_vpn  (pr_vpn),
        .key_asid (pr_asid),
        .hits     (pr_hits)
    );

    tlbp_first_hit #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pr_pick (
        .hits  (pr_hits),
        .found (pr_found),
        .idx   (pr_win)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pr_miss   <= 1'b1;
            pr_result <= '1;
        end else begin
            pr_miss   <= !pr_found;
            pr_result <= pr_found ? {1'b0, pr_win} : '1;
        end
    end

    // Indexed read-back
    logic  rd_ok;
    slot_t rd_sel;
    assign rd_ok  = ({1'b0, rd_idx} < SLOT_CNT);
    assign rd_sel = slot_q[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_lo0  <= '0;
            rd_lo1  <= '0;
            rd_hi   <= '0;
            rd_mask <= '0;
        end else if (rd_ok) begin
            rd_lo0  <= pack_frame(rd_sel.even, rd_sel.glob);
            rd_lo1  <= pack_frame(rd_sel.odd, rd_sel.glob);
            rd_hi   <= pack_tag(rd_sel.vpn, rd_sel.asid);
            rd_mask <= pack_mask(rd_sel.mask);
        end else begin
            rd_lo0  <= '0;
            rd_lo1  <= '0;
            rd_hi   <= '0;
            rd_mask <= '0;
        end
    end

    // Victim pointer
    tlbp_rr_ptr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_rr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (flush),
        .adv   (rp_adv),
        .ptr   (rp_idx)
    );

endmodule

// File: rtl/tlbp_pair_chk.sv
module tlbp_pair_chk #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             rp_adv,
    input logic [IDX_W-1:0] rp_idx,
    input logic             pr_miss,
    input logic [IDX_W:0]   pr_result,
    input logic             lk_hit,
    input logic [IDX_W-1:0] lk_idx,
    input logic [31:0]      lk_lo0,
    input logic [31:0]      lk_lo1
);

    localparam logic [IDX_W-1:0] LAST     = IDX_W'(ENTRIES - 1);
    localparam logic [IDX_W:0]   SLOT_CNT = (IDX_W + 1)'(ENTRIES);

    // R8
    flush_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (rp_idx == '0));

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> ##2 !lk_hit);

    // R9
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !rp_adv) |=> $stable(rp_idx));

    // R9
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && rp_adv) |=>
            (rp_idx == (($past(rp_idx) == LAST) ? '0 : IDX_W'($past(rp_idx) + 1'b1))));

    // R5
    miss_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pr_miss |-> (&pr_result));

    // R5
    found_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pr_miss |-> (pr_result < SLOT_CNT));

    // R4
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_lo0 == '0 && lk_lo1 == '0 && lk_idx == '0));

endmodule

bind tlbp_pair_tlb tlbp_pair_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .rp_adv    (rp_adv),
    .rp_idx    (rp_idx),
    .pr_miss   (pr_miss),
    .pr_result (pr_result),
    .lk_hit    (lk_hit),
    .lk_idx    (lk_idx),
    .lk_lo0    (lk_lo0),
    .lk_lo1    (lk_lo1)
);

// File: tb/tb_tlbp_pair_tlb.sv
module tb_tlbp_pair_tlb;

    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [18:0] lk_vpn = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_hit;
    logic [2:0]  lk_idx;
    logic [31:0] lk_lo0, lk_lo1;
    logic [18:0] pr_vpn = '0;
    logic [7:0]  pr_asid = '0;
    logic        pr_miss;
    logic [3:0]  pr_result;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [18:0] wr_vpn = '0, wr_mask = '0;
    logic [7:0]  wr_asid = '0;
    logic        wr_global = 1'b0;
    logic [19:0] wr_pfn0 = '0, wr_pfn1 = '0;
    logic [2:0]  wr_attr0 = '0, wr_attr1 = '0;
    logic        wr_dirty0 = 1'b0, wr_valid0 = 1'b0, wr_dirty1 = 1'b0, wr_valid1 = 1'b0;
    logic [2:0]  rd_idx = '0;
    logic [31:0] rd_lo0, rd_lo1, rd_hi, rd_mask;
    logic        rp_adv = 1'b0;
    logic [2:0]  rp_idx;

    tlbp_pair_tlb #(.ENTRIES(N)) dut (.*);

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    bit [18:0] mv [N];
    bit [18:0] mm [N];
    bit [7:0]  ma [N];
    bit        mg [N];
    bit [19:0] f0 [N];
    bit [19:0] f1 [N];
    bit [2:0]  c0 [N];
    bit [2:0]  c1 [N];
    bit        d0 [N], d1 [N], v0 [N], v1 [N];
    int        mptr = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic bit [31:0] bpack(input bit [19:0] p, input bit [2:0] c,
                                        input bit d, input bit v, input bit g);
        return ({12'b0, p} << 6) | ({29'b0, c} << 3) | (32'(d) << 2) | (32'(v) << 1) | 32'(g);
    endfunction

    function automatic int ref_find(input bit [18:0] v, input bit [7:0] a);
        for (int i = 0; i < N; i++) begin
            if ((v0[i] || v1[i]) && (((v ^ mv[i]) & ~mm[i]) == 19'b0) && (mg[i] || a == ma[i]))
                return i;
        end
        return -1;
    endfunction

    function automatic void model_clear();
        for (int i = 0; i < N; i++) begin
            mv[i] = '0; mm[i] = '0; ma[i] = '0; mg[i] = 1'b0;
            f0[i] = '0; f1[i] = '0; c0[i] = '0; c1[i] = '0;
            d0[i] = 1'b0; d1[i] = 1'b0; v0[i] = 1'b0; v1[i] = 1'b0;
        end
    endfunction

    task automatic do_write(input int idx, input bit [18:0] v, input bit [18:0] m,
                            input bit [7:0] a, input bit g,
                            input bit [19:0] p0, input bit [2:0] a0, input bit dd0, input bit vv0,
                            input bit [19:0] p1, input bit [2:0] a1, input bit dd1, input bit vv1);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_vpn = v; wr_mask = m; wr_asid = a; wr_global = g;
        wr_pfn0 = p0; wr_attr0 = a0; wr_dirty0 = dd0; wr_valid0 = vv0;
        wr_pfn1 = p1; wr_attr1 = a1; wr_dirty1 = dd1; wr_valid1 = vv1;
        @(negedge clk);
        wr_en = 1'b0;
        if (idx < N) begin
            mv[idx] = v; mm[idx] = m; ma[idx] = a; mg[idx] = g;
            f0[idx] = p0; c0[idx] = a0; d0[idx] = dd0; v0[idx] = vv0;
            f1[idx] = p1; c1[idx] = a1; d1[idx] = dd1; v1[idx] = vv1;
        end
    endtask

    task automatic do_lookup(input string req, input bit [18:0] v, input bit [7:0] a);
        int e;
        lk_vpn = v; lk_asid = a; pr_vpn = v; pr_asid = a;
        @(negedge clk);
        e = ref_find(v, a);
        check({req, " hit"}, 64'(lk_hit), 64'(e >= 0));
        if (e >= 0) begin
            check({req, " idx"}, 64'(lk_idx), 64'(e));
            check({req, " lo0"}, 64'(lk_lo0), 64'(bpack(f0[e], c0[e], d0[e], v0[e], mg[e])));
            check({req, " lo1"}, 64'(lk_lo1), 64'(bpack(f1[e], c1[e], d1[e], v1[e], mg[e])));
            check({req, " R5 probe"}, 64'({pr_miss, pr_result}), 64'({1'b0, 4'(e)}));
        end else begin
            check({req, " R4 miss words"}, 64'({lk_idx, lk_lo0, lk_lo1}), 64'(0));
            check({req, " R5 probe"}, 64'({pr_miss, pr_result}), 64'({1'b1, 4'hF}));
        end
    endtask

    task automatic do_read(input string req, input int idx);
        rd_idx = 3'(idx);
        @(negedge clk);
        check({req, " lo0"}, 64'(rd_lo0), 64'(bpack(f0[idx], c0[idx], d0[idx], v0[idx], mg[idx])));
        check({req, " lo1"}, 64'(rd_lo1), 64'(bpack(f1[idx], c1[idx], d1[idx], v1[idx], mg[idx])));
        check({req, " hi"}, 64'(rd_hi), 64'(({13'b0, mv[idx]} << 11) | 32'(ma[idx])));
        check({req, " mask"}, 64'(rd_mask), 64'({13'b0, mm[idx]} << 11));
    endtask

    task automatic rp_step(input bit adv);
        rp_adv = adv;
        @(negedge clk);
        rp_adv = 1'b0;
        if (adv) mptr = (mptr + 1) % N;
        check(adv ? "R9 advance" : "R9 hold", 64'(rp_idx), 64'(mptr));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check("R10 lk_hit", 64'(lk_hit), 64'(0));
        check("R10 probe", 64'({pr_miss, pr_result}), 64'({1'b1, 4'hF}));
        check("R10 rp_idx", 64'(rp_idx), 64'(0));
        check("R10 rd words", 64'(rd_lo0 | rd_lo1 | rd_hi | rd_mask), 64'(0));

        // R1 / R2 basic match and identifier filter
        do_write(2, 19'h100, 19'h0, 8'd5, 1'b0, 20'hABCDE, 3'd3, 1'b1, 1'b1,
                 20'h12345, 3'd0, 1'b0, 1'b0);
        do_lookup("R1 exact", 19'h100, 8'd5);
        do_lookup("R2 asid mismatch", 19'h100, 8'd6);

        // R7 explicit field layout for slot 2
        rd_idx = 3'd2;
        @(negedge clk);
        check("R7 lo0 layout", 64'(rd_lo0), 64'h2AF379E);
        check("R7 lo1 layout", 64'(rd_lo1), 64'h48D140);
        check("R7 hi layout", 64'(rd_hi), 64'h80005);

        // R2 global override, R4 lowest index priority
        do_write(5, 19'h100, 19'h0, 8'd9, 1'b1, 20'h00777, 3'd2, 1'b0, 1'b1,
                 20'h00888, 3'd1, 1'b1, 1'b1);
        do_lookup("R2 global", 19'h100, 8'd6);
        do_lookup("R4 lowest wins", 19'h100, 8'd5);

        // R1 masked bits
        do_write(1, 19'h2F0, 19'h00F, 8'd5, 1'b0, 20'h00111, 3'd4, 1'b1, 1'b0,
                 20'h00222, 3'd5, 1'b0, 1'b1);
        do_lookup("R1 masked hit", 19'h2FA, 8'd5);
        do_lookup("R1 unmasked miss", 19'h3FA, 8'd5);
        rd_idx = 3'd1;
        @(negedge clk);
        check("R7 mask layout", 64'(rd_mask), 64'h7800);

        // R3 neither half valid
        do_write(0, 19'h400, 19'h0, 8'd5, 1'b1, 20'h00333, 3'd0, 1'b1, 1'b0,
                 20'h00444, 3'd0, 1'b1, 1'b0);
        do_lookup("R3 invalid slot", 19'h400, 8'd5);

        // R6 out-of-range loads ignored
        do_write(8, 19'h500, 19'h0, 8'd1, 1'b1, 20'h1, 3'd1, 1'b1, 1'b1, 20'h2, 3'd1, 1'b1, 1'b1);
        do_write(15, 19'h500, 19'h0, 8'd1, 1'b1, 20'h1, 3'd1, 1'b1, 1'b1, 20'h2, 3'd1, 1'b1, 1'b1);
        do_lookup("R6 oob ignored", 19'h500, 8'd1);
        for (int i = 0; i < N; i++) do_read("R6 table intact", i);

        // R9 pointer advance, wrap, hold
        for (int i = 0; i < 9; i++) rp_step(1'b1);
        rp_step(1'b0);
        rp_step(1'b0);

        // R8 flush with a simultaneous load
        flush = 1'b1;
        wr_en = 1'b1; wr_idx = 4'd3; wr_vpn = 19'h100; wr_asid = 8'd5;
        wr_valid0 = 1'b1; wr_valid1 = 1'b1;
        @(negedge clk);
        flush = 1'b0; wr_en = 1'b0;
        model_clear();
        mptr = 0;
        check("R8 ptr cleared", 64'(rp_idx), 64'(0));
        do_lookup("R8 flushed", 19'h100, 8'd5);
        for (int i = 0; i < N; i++) do_read("R8 zeroed", i);

        // Random mix
        for (int k = 0; k < 400; k++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 3) begin
                int idx;
                bit [18:0] msk;
                idx = ($urandom_range(0, 7) == 0) ? int'($urandom_range(8, 15)) : int'($urandom_range(0, 7));
                case ($urandom_range(0, 2))
                    0: msk = 19'h0;
                    1: msk = 19'h1;
                    default: msk = 19'h3;
                endcase
                do_write(idx, 19'($urandom_range(0, 15)), msk, 8'($urandom_range(0, 3)),
                         1'($urandom_range(0, 1)),
                         20'($urandom), 3'($urandom), 1'($urandom), 1'($urandom),
                         20'($urandom), 3'($urandom), 1'($urandom), 1'($urandom));
            end else if (op < 8) begin
                do_lookup("R1 R2 R3 R4 random", 19'($urandom_range(0, 15)), 8'($urandom_range(0, 3)));
            end else begin
                do_read("R7 random", int'($urandom_range(0, 7)));
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule